// File: doc/BRIEF.md
# Even-Ratio CPU Clock Prescaler

This block derives a slower CPU clock from a fast reference clock. Software picks the ratio by writing a 4-bit divisor code into a memory-mapped control register. The division ratio is twice the code, so codes 1 to 15 give ratios 2 to 30. The block drives a square wave with exact 50% duty. It also drives a single-cycle enable pulse that marks each rising edge of that wave. Downstream logic can use either one.

A newly written code does not change the divider at once. It waits as a pending value and is loaded when the output is about to rise, so every output period is made entirely from one ratio. Code zero has no meaning: a write that carries it is dropped and sets a sticky error bit, which software reads and clears in a status register. The block also compares the running CPU ratio with the bus-clock ratio given on an input port, and raises a flag when the CPU clock would run slower than the bus clock.

Top module: `clkpre_top`

## Requirements
- R1: With active code N, `cpu_clk_out` stays high for exactly N reference cycles and then low for exactly N reference cycles, which gives a period of 2×N cycles at 50% duty.
- R2: Synchronous active-high `rst` sets the active and pending code to 4'hF (ratio 30), drives `cpu_clk_out`, `cpu_clk_en` and `ratio_violation` low, and clears the error bit. After reset the control register reads 32'h0000000F and the status register reads 0.
- R3: A write to the control register with bits 3:0 equal to zero is dropped. The register keeps its previous code and the output keeps its previous ratio.
- R4: A dropped zero-code write sets bit 0 of the status register (byte offset 0x20). The bit stays set until a write to 0x20 with bit 0 = 1. A write to 0x20 with bit 0 = 0 leaves it unchanged.
- R5: The control register is at byte offset 0x1C. Bits 3:0 hold the divisor code. Bits 31:4 always read zero, and whatever is written to them is discarded.
- R6: A new code is applied only at the next rising edge of `cpu_clk_out`. The period in progress completes with the old code, and the high phase that starts at that edge already uses the new code.
- R7: `cpu_clk_en` is high for exactly one reference cycle, the cycle right before each rising edge of `cpu_clk_out`.
- R8: One cycle after the inputs settle, `ratio_violation` is high when 2×(active code) is greater than `bus_ratio`, and low otherwise. Equal ratios are not a violation.
- R9: Reads from offsets other than 0x1C and 0x20 return zero. Writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| bus_ratio | input | 6 | Current bus-clock division ratio |
| cpu_clk_out | output | 1 | Divided CPU clock, 50% duty |
| cpu_clk_en | output | 1 | One-cycle pulse before each rising edge of `cpu_clk_out` |
| ratio_violation | output | 1 | CPU ratio exceeds bus ratio |

## Verification
Several properties are checked on every cycle. The active code is never zero. The active code changes only together with a rising output edge. Each enable pulse is followed by a rise. No output phase runs longer than the largest code. A zero-code write leaves the pending code unchanged and sets the error bit. Reserved control bits always read zero. The exact high and low phase lengths for each code, how a divisor change made mid-period plays out, the clear behaviour of the status bit, unmapped addresses and the comparator's boundary at equal ratios depend on particular stimulus, so only the bench scenarios demonstrate them.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT
    } reg_sel_e;

endpackage

// File: rtl/clkpre_regs.sv
module clkpre_regs
    import clkpre_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CODE_W = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 'h1C,
    parameter logic [ADDR_W-1:0] STAT_OFF = 'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CODE_W-1:0] pending_code,
    output logic              reject_err
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              err;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     unused_bits;

    // reserved write bits are discarded
    assign unused_bits = ^wdata[DATA_W-1:CODE_W];

    always_comb begin
        if (addr == CTRL_OFF)      sel = SEL_CTRL;
        else if (addr == STAT_OFF) sel = SEL_STAT;
        else                       sel = SEL_NONE;
    end

    always_comb begin
        regs_d = regs_q;
        if (we && sel == SEL_CTRL) begin
            if (wdata[CODE_W-1:0] != '0) regs_d.code = wdata[CODE_W-1:0];
            else                         regs_d.err  = 1'b1;
        end
        if (we && sel == SEL_STAT && wdata[0]) begin
            regs_d.err = 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = {{(DATA_W-CODE_W){1'b0}}, regs_q.code};
            SEL_STAT: rdata = {{(DATA_W-1){1'b0}}, regs_q.err};
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.code <= '1;
            regs_q.err  <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pending_code = regs_q.code;
    assign reject_err   = regs_q.err;

endmodule

// File: rtl/clkpre_divider.sv
module clkpre_divider #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] pending_code,
    output logic [CODE_W-1:0] active_code,
    output logic              clk_out,
    output logic              clk_en
);

    typedef struct packed {
        logic [CODE_W-1:0] cnt;
        logic              out;
        logic [CODE_W-1:0] active;
    } div_t;

    div_t div_d, div_q;
    logic wrap;

    assign wrap = (div_q.cnt == div_q.active - CODE_W'(1));

    always_comb begin
        div_d = div_q;
        if (wrap) begin
            div_d.cnt = '0;
            div_d.out = ~div_q.out;
            // a new ratio is taken only at the low-to-high boundary
            if (!div_q.out) div_d.active = pending_code;
        end else begin
            div_d.cnt = div_q.cnt + CODE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q.cnt    <= '0;
            div_q.out    <= 1'b0;
            div_q.active <= '1;
        end else begin
            div_q <= div_d;
        end
    end

    assign active_code = div_q.active;
    assign clk_out     = div_q.out;
    assign clk_en      = wrap & ~div_q.out;

endmodule

// File: rtl/clkpre_ratio_check.sv
module clkpre_ratio_check #(
    parameter int CODE_W  = 4,
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  active_code,
    input  logic [RATIO_W-1:0] bus_ratio,
    output logic               violation
);

    typedef struct packed {
        logic viol;
    } chk_t;

    chk_t               chk_d, chk_q;
    logic [RATIO_W-1:0] cpu_ratio;

    always_comb begin
        cpu_ratio  = {{(RATIO_W-CODE_W-1){1'b0}}, active_code, 1'b0};
        chk_d.viol = (cpu_ratio > bus_ratio);
    end

    always_ff @(posedge clk) begin
        if (rst) chk_q.viol <= 1'b0;
        else     chk_q      <= chk_d;
    end

    assign violation = chk_q.viol;

endmodule

// File: rtl/clkpre_top.sv
module clkpre_top #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CODE_W  = 4,
    parameter int RATIO_W = 6,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 'h1C,
    parameter logic [ADDR_W-1:0] STAT_OFF = 'h20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [RATIO_W-1:0] bus_ratio,
    output logic               cpu_clk_out,
    output logic               cpu_clk_en,
    output logic               ratio_violation
);

    logic [CODE_W-1:0] pending_code;
    logic [CODE_W-1:0] active_code;
    logic              reject_err;

    clkpre_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
        .CTRL_OFF(CTRL_OFF), .STAT_OFF(STAT_OFF)
    ) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .pending_code(pending_code), .reject_err(reject_err)
    );

    clkpre_divider #(.CODE_W(CODE_W)) u_div (
        .clk(clk), .rst(rst), .pending_code(pending_code),
        .active_code(active_code), .clk_out(cpu_clk_out), .clk_en(cpu_clk_en)
    );

    clkpre_ratio_check #(.CODE_W(CODE_W), .RATIO_W(RATIO_W)) u_cmp (
        .clk(clk), .rst(rst), .active_code(active_code),
        .bus_ratio(bus_ratio), .violation(ratio_violation)
    );

endmodule

// File: rtl/clkpre_checker.sv
module clkpre_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CODE_W = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 'h1C
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cpu_clk_out,
    input logic              cpu_clk_en,
    input logic              ratio_violation,
    input logic [CODE_W-1:0] pending_code,
    input logic [CODE_W-1:0] active_code,
    input logic              reject_err
);

    logic              prev_q;
    logic [CODE_W:0]   run_q;
    logic              zero_wr;

    assign zero_wr = bus_we && (bus_addr == CTRL_OFF) && (bus_wdata[CODE_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= cpu_clk_out;
            run_q  <= (cpu_clk_out != prev_q) ? (CODE_W+1)'(1) : run_q + (CODE_W+1)'(1);
        end
    end

    p_phase_len_r1: assert property (@(posedge clk) disable iff (rst)
        run_q <= (CODE_W+1)'((1 << CODE_W) - 1));

    p_reset_state_r2: assert property (@(posedge clk)
        rst |=> (active_code == '1 && !cpu_clk_out && !ratio_violation && !reject_err));

    p_active_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        active_code != '0);

    p_zero_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
        zero_wr |=> pending_code == $past(pending_code));

    p_zero_write_flag_r4: assert property (@(posedge clk) disable iff (rst)
        zero_wr |=> reject_err);

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CTRL_OFF) |-> bus_rdata[DATA_W-1:CODE_W] == '0);

    p_load_at_rise_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_code) |-> $rose(cpu_clk_out));

    p_en_before_rise_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |=> $rose(cpu_clk_out));

endmodule

bind clkpre_top clkpre_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .CTRL_OFF(CTRL_OFF)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_clk_out(cpu_clk_out),
    .cpu_clk_en(cpu_clk_en), .ratio_violation(ratio_violation),
    .pending_code(pending_code), .active_code(active_code), .reject_err(reject_err)
);

// File: tb/clkpre_top_test.sv
module clkpre_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  bus_ratio = 6'd30;
    logic        cpu_clk_out, cpu_clk_en, ratio_violation;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic last_en;

    localparam logic [7:0] CTRL = 8'h1C;
    localparam logic [7:0] STAT = 8'h20;

    always #5 clk = ~clk;

    clkpre_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ratio(bus_ratio),
        .cpu_clk_out(cpu_clk_out), .cpu_clk_en(cpu_clk_en),
        .ratio_violation(ratio_violation)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // returns on the first sample where the output is high after being low
    task automatic sync_rise();
        logic prev;
        prev = cpu_clk_out;
        last_en = cpu_clk_en;
        forever begin
            @(negedge clk);
            if (cpu_clk_out && !prev) break;
            prev = cpu_clk_out;
            last_en = cpu_clk_en;
        end
    endtask

    task automatic count_run(input logic val, output int n);
        n = 0;
        while (cpu_clk_out == val) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(CTRL, d);
        check(d == 32'hF, "R2 ctrl reset", d, 32'hF);
        rd(STAT, d);
        check(d == 0, "R2 status reset", d, 0);
        check(cpu_clk_out == 0 && ratio_violation == 0, "R2 outputs low",
              {cpu_clk_out, ratio_violation}, 0);
    endtask

    task automatic t_measure(input int code);
        int h, l;
        wr(CTRL, 32'(code));
        sync_rise();
        sync_rise();
        check(last_en == 1'b1, "R7 enable before rise", last_en, 1);
        count_run(1'b1, h);
        count_run(1'b0, l);
        check(h == code, "R1 high phase", h, code);
        check(l == code, "R1 low phase", l, code);
    endtask

    task automatic t_midchange();
        int h, l, h2;
        t_measure(3);
        // now at the first high sample of a ratio-6 period
        h = 1;
        bus_addr = CTRL; bus_wdata = 32'd7; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        while (cpu_clk_out) begin h++; @(negedge clk); end
        count_run(1'b0, l);
        count_run(1'b1, h2);
        check(h == 3, "R6 old high kept", h, 3);
        check(l == 3, "R6 old low kept", l, 3);
        check(h2 == 7, "R6 new ratio at rise", h2, 7);
    endtask

    task automatic t_registers();
        logic [31:0] d;
        int h, l;
        wr(CTRL, 32'hFFFF_FFF5);
        rd(CTRL, d);
        check(d == 32'h5, "R5 reserved bits zero", d, 5);
        wr(CTRL, 32'hFFFF_FFF0);
        rd(CTRL, d);
        check(d == 32'h5, "R3 zero code dropped", d, 5);
        rd(STAT, d);
        check(d == 32'h1, "R4 error set", d, 1);
        sync_rise();
        count_run(1'b1, h);
        count_run(1'b0, l);
        check(h == 5 && l == 5, "R3 ratio kept", h + l, 10);
        wr(STAT, 32'h0);
        rd(STAT, d);
        check(d == 32'h1, "R4 error sticky", d, 1);
        wr(STAT, 32'h1);
        rd(STAT, d);
        check(d == 32'h0, "R4 error cleared", d, 0);
        rd(8'h40, d);
        check(d == 0, "R9 unmapped read", d, 0);
        wr(8'h40, 32'h3);
        rd(CTRL, d);
        check(d == 32'h5, "R9 unmapped write", d, 5);
    endtask

    task automatic t_violation();
        t_measure(2);
        bus_ratio = 6'd4;
        repeat (2) @(negedge clk);
        check(ratio_violation == 0, "R8 equal ratio", ratio_violation, 0);
        bus_ratio = 6'd3;
        repeat (2) @(negedge clk);
        check(ratio_violation == 1, "R8 cpu slower", ratio_violation, 1);
        t_measure(15);
        bus_ratio = 6'd30;
        repeat (2) @(negedge clk);
        check(ratio_violation == 0, "R8 equal at max", ratio_violation, 0);
        bus_ratio = 6'd28;
        repeat (2) @(negedge clk);
        check(ratio_violation == 1, "R8 max vs 28", ratio_violation, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        for (int c = 1; c <= 15; c++) t_measure(c);
        t_midchange();
        t_registers();
        t_violation();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule